// File: doc/BRIEF.md
# Two-Element Feedback Loop Oscillator Model

This block is a small test circuit built around a feedback loop. Two delay elements, called A and B, hold the loop state. A net of zero-delay gates computes the next value of each element from the current values of both elements and from two static control inputs. Each delay element is a registered shift chain whose length is a parameter, so an element with delay d presents its gate result d clock cycles after the gate computed it.

The control pair (`mode_a`, `mode_b`) selects one of four behaviours, written here as the pair {mode_a, mode_b}:
- 00 clears the loop.
- 10 makes the loop keep its contents.
- 01 gives an oscillation of period 2.
- 11 gives an oscillation of period 3.

With delays larger than one, each period stretches accordingly. The block is meant as a device under observation for logic that finds out whether a circuit has settled and, if not, how long its cycle is.

An asynchronous active-low reset clears every stage. The reset is released into the loop through a short synchronizer, so the loop starts running `SYNC_STAGES` rising edges after `rst_n` goes high.

Top module: `cyclic_pair_osc`

## Requirements
- R1: Driving `rst_n` low clears `tap_a` and `tap_b` to 0 at once, without waiting for a clock edge, and they stay 0 while reset is held. After `rst_n` rises, the loop runs only once `SYNC_STAGES` (default 2) rising edges have passed.
- R2: The output of element A after edge n+1 is the A gate result computed from the control pair and the outputs of cycle n+1−`DLY_A`. Element B works the same way with `DLY_B`. Both defaults are 2. Cycles before the loop starts count as pair 00 with outputs 00.
- R3: With pair 00, both gates yield 0, so both outputs are 0 once the pair has been held for max(`DLY_A`, `DLY_B`) edges.
- R4: With pair 10, each gate passes on its own element's current output. For unit delays the outputs stay constant; for delay d the sequence of each output repeats every d cycles.
- R5: With pair 01, the A gate yields 0 and the B gate yields the inverse of `tap_b`. For unit delays, starting from 00, the sequence of {tap_a, tap_b} is 00, 01, 00, 01, and so on.
- R6: With pair 11, the next A is (not A) and B, and the next B is (not A) and (not B). For unit delays, starting from 00, the sequence of {tap_a, tap_b} is 00, 01, 10 and then repeats. With equal delays, the outputs are never both 1 once the pair has been held for the delay.
- R7: With both delays equal to 2, pair 11 applied from the cleared state gives the sequence 00, 00, 01, 01, 10, 10. The sequence repeats every 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_a | input | 1 | First static control input; the high bit of the control pair |
| mode_b | input | 1 | Second static control input; the low bit of the control pair |
| tap_a | output | 1 | Output of delay element A |
| tap_b | output | 1 | Output of delay element B |

## Verification
The assertions check the following on every cycle:
- Outputs are cleared while reset is held.
- Outputs are zero once pair 00 has persisted for the longest delay.
- `tap_a` is low once pair 01 has persisted for `DLY_A` edges.
- The state 11 never appears under a settled pair 11 when the delays are equal.

Those properties need only a run counter in the checker. The exact orderings need the bench's scenarios, which compare every cycle against a history-based model for both a two-cycle and a unit-delay instance. These orderings are:
- the period-2 and period-3 rings;
- the six-cycle stretched ring;
- the repeat of a held pattern;
- the response to mode changes in mid-sequence.

// File: rtl/cpo_pkg.sv
package cpo_pkg;

  // Loop behaviour selected by the control pair {mode_a, mode_b}
  typedef enum logic [1:0] {
    LOOP_CLEAR  = 2'b00,
    LOOP_TOGGLE = 2'b01,
    LOOP_KEEP   = 2'b10,
    LOOP_RING   = 2'b11
  } loop_mode_e;

  // State of the two loop elements
  typedef struct packed {
    logic a;
    logic b;
  } pair_t;

  function automatic loop_mode_e decode_mode(input logic in_a, input logic in_b);
    return loop_mode_e'({in_a, in_b});
  endfunction

endpackage

// File: rtl/cpo_reset_sync.sv
module cpo_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_d;
  logic [STAGES-1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cpo_loop_logic.sv
module cpo_loop_logic
  import cpo_pkg::*;
(
  input  logic  mode_a,
  input  logic  mode_b,
  input  pair_t cur,
  output pair_t nxt
);

  loop_mode_e mode;

  always_comb begin
    mode = decode_mode(mode_a, mode_b);
    nxt  = '0;
    case (mode)
      LOOP_CLEAR: begin
        nxt = '0;
      end
      LOOP_KEEP: begin
        nxt = cur;
      end
      LOOP_TOGGLE: begin
        nxt.a = 1'b0;
        nxt.b = !cur.b;
      end
      LOOP_RING: begin
        nxt.a = !cur.a && cur.b;
        nxt.b = !cur.a && !cur.b;
      end
      default: begin
        nxt = '0;
      end
    endcase
  end

endmodule

// File: rtl/cpo_delay_chain.sv
module cpo_delay_chain #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (DEPTH == 1) begin : g_single
      logic stg_d;
      logic stg_q;

      always_comb begin
        stg_d = din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q <= 1'b0;
        end else begin
          stg_q <= stg_d;
        end
      end

      assign dout = stg_q;
    end else begin : g_shift
      logic [DEPTH-1:0] sr_d;
      logic [DEPTH-1:0] sr_q;

      always_comb begin
        sr_d = {sr_q[DEPTH-2:0], din};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q <= '0;
        end else begin
          sr_q <= sr_d;
        end
      end

      assign dout = sr_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/cyclic_pair_osc.sv
module cyclic_pair_osc
  import cpo_pkg::*;
#(
  parameter int DLY_A       = 2,
  parameter int DLY_B       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_a,
  input  logic mode_b,
  output logic tap_a,
  output logic tap_b
);

  logic  rst_core_n;
  pair_t cur;
  pair_t nxt;

  cpo_reset_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rsync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  always_comb begin
    cur.a = tap_a;
    cur.b = tap_b;
  end

  cpo_loop_logic u_logic (
    .mode_a(mode_a),
    .mode_b(mode_b),
    .cur   (cur),
    .nxt   (nxt)
  );

  cpo_delay_chain #(
    .DEPTH(DLY_A)
  ) u_chain_a (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  (nxt.a),
    .dout (tap_a)
  );

  cpo_delay_chain #(
    .DEPTH(DLY_B)
  ) u_chain_b (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  (nxt.b),
    .dout (tap_b)
  );

endmodule

// File: rtl/cpo_checker.sv
module cpo_checker #(
  parameter int DLY_A = 2,
  parameter int DLY_B = 2
) (
  input logic clk,
  input logic rst_n,
  input logic mode_a,
  input logic mode_b,
  input logic tap_a,
  input logic tap_b
);

  localparam int MAXD = (DLY_A > DLY_B) ? DLY_A : DLY_B;
  localparam int CW   = $clog2(MAXD + 1) + 1;

  logic [1:0]    pair_q;
  logic [CW-1:0] run_q;
  logic          held_q;

  // Marks that reset was already low at the previous edge
  always_ff @(posedge clk) begin
    held_q <= !rst_n;
  end

  // Count consecutive edges that sampled the same control pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= 2'b00;
      run_q  <= '0;
    end else begin
      pair_q <= {mode_a, mode_b};
      if ({mode_a, mode_b} != pair_q) begin
        run_q <= CW'(1);
      end else if (run_q < CW'(MAXD)) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_clear_in_reset_R1: assert property (@(posedge clk)
    (held_q && !rst_n) |=> (tap_a == 1'b0 && tap_b == 1'b0));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_q == 2'b00 && run_q >= CW'(MAXD)) |-> (tap_a == 1'b0 && tap_b == 1'b0));

  assert_toggle_a_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_q == 2'b01 && run_q >= CW'(DLY_A)) |-> (tap_a == 1'b0));

  assert_ring_no_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (DLY_A == DLY_B && pair_q == 2'b11 && run_q >= CW'(MAXD)) |-> !(tap_a && tap_b));

endmodule

bind cyclic_pair_osc cpo_checker #(
  .DLY_A(DLY_A),
  .DLY_B(DLY_B)
) u_cpo_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .mode_a(mode_a),
  .mode_b(mode_b),
  .tap_a (tap_a),
  .tap_b (tap_b)
);

// File: tb/test_cyclic_pair_osc.sv
`timescale 1ns/1ps
module test_cyclic_pair_osc;

  localparam int WA = 2;
  localparam int WB = 2;
  localparam int UA = 1;
  localparam int UB = 1;
  localparam int HMAX = 1024;

  logic clk;
  logic rst_n;
  logic mode_a;
  logic mode_b;
  logic tap_a_w, tap_b_w;
  logic tap_a_u, tap_b_u;

  int n_checks;
  int n_fails;
  int n_idx;
  bit done;

  logic [1:0] in_h [0:HMAX-1];
  logic [1:0] w_h  [0:HMAX-1];
  logic [1:0] u_h  [0:HMAX-1];

  typedef struct {
    logic [1:0] exp_w;
    logic [1:0] exp_u;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  cyclic_pair_osc #(.DLY_A(WA), .DLY_B(WB)) i_cyclic_pair_osc (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .tap_a(tap_a_w), .tap_b(tap_b_w)
  );

  cyclic_pair_osc #(.DLY_A(UA), .DLY_B(UB)) i_cyclic_pair_osc_unit (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .tap_a(tap_a_u), .tap_b(tap_b_u)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Gate behaviour per R3..R6; inp = {mode_a, mode_b}, st = {A, B}
  function automatic logic [1:0] gate_ref(input logic [1:0] inp, input logic [1:0] st);
    case (inp)
      2'b00:   return 2'b00;
      2'b10:   return st;
      2'b01:   return {1'b0, ~st[0]};
      default: return {~st[1] & st[0], ~st[1] & ~st[0]};
    endcase
  endfunction

  // Output after edge now+1 per R2
  function automatic logic [1:0] predict(input int now, input int da, input int db, input bit wide);
    logic [1:0] ga;
    logic [1:0] gb;
    int ia;
    int ib;
    ia = now + 1 - da;
    ib = now + 1 - db;
    ga = (ia < 0) ? 2'b00 : gate_ref(in_h[ia], wide ? w_h[ia] : u_h[ia]);
    gb = (ib < 0) ? 2'b00 : gate_ref(in_h[ib], wide ? w_h[ib] : u_h[ib]);
    return {ga[1], gb[0]};
  endfunction

  task automatic check2(input logic [1:0] act, input logic [1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies a pair for a number of cycles and queues expected outputs
  task automatic drive(input logic a, input logic b, input int cycles, input string tag);
    for (int k = 0; k < cycles; k++) begin
      sb_item_t it;
      @(negedge clk);
      mode_a = a;
      mode_b = b;
      in_h[n_idx] = {a, b};
      it.exp_w = predict(n_idx, WA, WB, 1'b1);
      it.exp_u = predict(n_idx, UA, UB, 1'b0);
      it.tag   = tag;
      w_h[n_idx + 1] = it.exp_w;
      u_h[n_idx + 1] = it.exp_u;
      sb_q.push_back(it);
      n_idx++;
    end
  endtask

  // Monitor: pops and compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check2({tap_a_w, tap_b_w}, it.exp_w, {it.tag, " delay2"});
        check2({tap_a_u, tap_b_u}, it.exp_u, {it.tag, " delay1"});
      end
    end
  end

  task automatic start_history();
    n_idx  = 0;
    w_h[0] = 2'b00;
    u_h[0] = 2'b00;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) @(negedge clk);
    start_history();
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    mode_a   = 1'b0;
    mode_b   = 1'b0;
    start_history();
    for (int k = 0; k < 3; k++) @(posedge clk);
    #2;
    // R1: cleared while reset is held
    check2({tap_a_w, tap_b_w}, 2'b00, "R1 reset delay2");
    check2({tap_a_u, tap_b_u}, 2'b00, "R1 reset delay1");
    release_reset();

    // R6 and R7 ring from the cleared state; R2 timing throughout
    drive(1'b1, 1'b1, 14, "R7 R6 R2 ring");
    // R3 clear
    drive(1'b0, 1'b0, 5, "R3 clear");
    // R5 toggle from cleared state
    drive(1'b0, 1'b1, 8, "R5 toggle");
    // R4 keep after ring has moved state
    drive(1'b1, 1'b1, 5, "R6 ring prep");
    drive(1'b1, 1'b0, 8, "R4 keep");
    // mode changes mid-sequence
    drive(1'b0, 1'b1, 3, "R5 toggle mid");
    drive(1'b1, 1'b1, 7, "R6 ring mid");
    drive(1'b1, 1'b0, 6, "R4 keep mid");
    drive(1'b0, 1'b0, 4, "R3 clear mid");
    drive(1'b1, 1'b1, 9, "R2 ring again");
    @(negedge clk);
    @(negedge clk);

    // R1: asynchronous clear during oscillation
    rst_n = 1'b0;
    #1;
    check2({tap_a_w, tap_b_w}, 2'b00, "R1 async delay2");
    check2({tap_a_u, tap_b_u}, 2'b00, "R1 async delay1");
    mode_a = 1'b0;
    mode_b = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check2({tap_a_w, tap_b_w}, 2'b00, "R1 held delay2");
    check2({tap_a_u, tap_b_u}, 2'b00, "R1 held delay1");
    release_reset();

    drive(1'b1, 1'b1, 12, "R7 ring after reset");
    @(negedge clk);
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule